// File: doc/BRIEF.md
# Forward-Converter Switching Waveform Generator with Dead-Time

This block produces the gate-drive timing for a forward converter with synchronous rectification. A free-running period counter defines a fixed switching frequency. A reference on-pulse opens at the start of each period and closes at the half-period mark, so the duty can never exceed one half. An external peak-current comparator can close the pulse early. Only its first rising edge in a period counts, which serves both cycle-by-cycle current limiting and peak current-mode control.

Two complementary gates come from the reference. The main gate drives the primary switches together with the forward rectifier. The complementary gate drives the freewheeling rectifier. Each gate turns on a programmable number of clocks after its source rises and turns off at once when its source falls, so the two gates never conduct together. The dead-time setting and the run enable take effect only at a period boundary.

Once per period the block emits a terminal-count pulse that starts the control-loop update. It also emits a sample strobe one clock before the main gate would turn on, so the output-voltage sample lands in a quiet part of the period.

Top module: `fwd_pwm`

## Requirements
- R1: `period_tc` is a one-clock pulse that repeats every PERIOD clocks (480 by default). It is high in the clock in which the internal count is 0.
- R2: With no comparator edge and a dead-time of 0, `gate_main` is high for exactly ON_MAX clocks per period (240 by default). It is high in the clocks that follow the `period_tc` clock.
- R3: The first rising edge of `cmp_trip` seen during a period ends that period's on-pulse. Later edges in the same period have no effect, and an edge outside the on-window does not shorten the next period's pulse.
- R4: `cmp_trip` passes through a two-flop synchroniser. If `cmp_trip` is first sampled high at the clock edge that ends count c, where c is inside the on-window, then `gate_main` is high for c+3 clocks when the dead-time is 0.
- R5: `gate_main` rises `dead_cfg` clocks after the reference rises. `gate_comp` rises `dead_cfg` clocks after the reference falls. Each gate falls in the same clock as its source, and the two gates are never high together.
- R6: `dead_cfg` is sampled only at the period boundary. A change made mid-period leaves both gates of that period unchanged and applies from the next period.
- R7: If the on-pulse is shorter than the dead-time, `gate_main` gives no pulse in that period.
- R8: All gates and the strobe are low during reset and while disabled. Setting `enable` takes effect at the next period start. Clearing `enable` forces the gates low by the second clock after the edge that samples it low.
- R9: When the dead-time is at least 1, `sample_stb` gives one one-clock pulse per period, `dead_cfg` clocks after the `period_tc` clock and one clock before `gate_main` rises. Both gates are low while it is high. With a dead-time of 0 it stays low.
- R10: `period_tc` keeps running with the same spacing whether or not `enable` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching time base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request; set as the last initialisation step |
| dead_cfg | input | DT_W (8) | Dead-time in clocks, 0 to 255 |
| cmp_trip | input | 1 | Asynchronous peak-current comparator output |
| gate_main | output | 1 | Primary switch and forward rectifier gate |
| gate_comp | output | 1 | Freewheeling rectifier gate |
| period_tc | output | 1 | One-clock pulse per period for the loop update |
| sample_stb | output | 1 | Output-voltage sample strobe inside the dead-time |

## Verification
The hardest case to reach from the ports is a comparator edge that arrives at a chosen count inside the on-window, followed by a second edge in the same period. Another is a dead-time change that lands mid-period. The bench locks onto `period_tc` and counts falling edges from it, so it knows the count at which it drives `cmp_trip` or changes `dead_cfg`. It then measures the gate widths over the period window that follows. A behavioural model built on integers runs alongside the block and predicts every output in every clock.

// File: rtl/fpwm_pkg.sv
// Package: fpwm_pkg
// Shared types for the forward-converter waveform generator.
// Assumes: nothing beyond IEEE 1800-2017.
package fpwm_pkg;
    // Gate channel kind; only the main channel produces the sample strobe.
    typedef enum logic {
        CH_MAIN = 1'b0,
        CH_COMP = 1'b1
    } fpwm_ch_e;
endpackage

// File: rtl/fpwm_timebase.sv
// Module: fpwm_timebase
// Free-running period counter. Holds the settings that change only at the
// period boundary (run flag and dead-time) and raises the terminal-count pulse.
// Assumes: 1 < ON_MAX < PERIOD. The run flag clears at once when enable drops.
module fpwm_timebase #(
    parameter int PERIOD = 480,
    parameter int ON_MAX = 240,
    parameter int DT_W   = 8,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DT_W-1:0]  dead_cfg,
    output logic [CNT_W-1:0] cnt_o,
    output logic             win_o,
    output logic             last_o,
    output logic             run_o,
    output logic [DT_W-1:0]  dt_o,
    output logic             tc_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] ON_LIM   = CNT_W'(ON_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DT_W-1:0]  dt_q;
    logic             tc_q;

    // Decode the last count and the on-window from the count.
    always_comb begin
        last_o = (cnt_q == CNT_LAST);
        win_o  = (cnt_q < ON_LIM);
    end

    // Advance the count and wrap it at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (last_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // Run flag: sets only at the boundary, clears as soon as enable drops.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (!enable) run_q <= 1'b0;
        else if (last_o)  run_q <= 1'b1;
    end

    // Dead-time copy that is taken at the boundary, so no runt pulse can occur.
    always_ff @(posedge clk) begin
        if (!rst_n)      dt_q <= '0;
        else if (last_o) dt_q <= dead_cfg;
    end

    // Terminal-count pulse, high in the clock in which the count is 0.
    always_ff @(posedge clk) begin
        if (!rst_n) tc_q <= 1'b0;
        else        tc_q <= last_o;
    end

    assign cnt_o = cnt_q;
    assign run_o = run_q;
    assign dt_o  = dt_q;
    assign tc_o  = tc_q;
endmodule

// File: rtl/fpwm_cmp_edge.sv
// Module: fpwm_cmp_edge
// Brings the asynchronous comparator into the clock domain through two flops,
// then finds its rising edge with a third flop.
// Assumes: a comparator pulse lasts at least two clocks to be seen reliably.
module fpwm_cmp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_in,
    output logic rise_o
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Synchroniser chain plus the delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= cmp_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // One-clock rise indication.
    always_comb rise_o = sync_q && !prev_q;
endmodule

// File: rtl/fpwm_onctl.sv
// Module: fpwm_onctl
// Forms the reference on-pulse: the on-window gated by the run flag, cut
// short by the first comparator rise. The termination latch clears at the
// last count, so each period starts unterminated.
// Assumes: rise_i is already synchronous to clk.
module fpwm_onctl (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic win_i,
    input  logic last_i,
    input  logic rise_i,
    output logic ref_o
);
    logic term_q;

    // Sticky termination flag, cleared at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)      term_q <= 1'b0;
        else if (last_i) term_q <= 1'b0;
        else if (rise_i) term_q <= 1'b1;
    end

    // Reference pulse seen by both gate channels.
    always_comb ref_o = run_i && win_i && !term_q;
endmodule

// File: rtl/fpwm_dt_chan.sv
// Module: fpwm_dt_chan
// One gate channel with rising-edge delay. The gate turns on once its source
// has been high for dt clocks and drops in the clock its source drops. The
// main channel also marks the clock just before its turn-on.
// Assumes: dt is steady while the source is high (it changes at the boundary).
module fpwm_dt_chan
    import fpwm_pkg::*;
#(
    parameter int       DT_W = 8,
    parameter fpwm_ch_e KIND = CH_MAIN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_i,
    input  logic [DT_W-1:0] dt_i,
    output logic            gate_o,
    output logic            pre_o
);
    localparam logic [DT_W-1:0] LEN_MAX = '1;

    logic [DT_W-1:0] len_q;
    logic            gate_q;
    logic            gate_nxt;

    // Count how long the source has been high, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)               len_q <= '0;
        else if (!src_i)          len_q <= '0;
        else if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
    end

    // Turn-on condition for the gate.
    always_comb gate_nxt = src_i && (len_q >= dt_i);

    // Registered gate so the pin never glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_nxt;
    end

    assign gate_o = gate_q;

    // The pre-turn-on marker exists only on the main channel.
    generate
        if (KIND == CH_MAIN) begin : g_pre
            logic pre_q;
            // Register the marker for the clock just before the gate rises.
            always_ff @(posedge clk) begin
                if (!rst_n) pre_q <= 1'b0;
                else        pre_q <= src_i && (dt_i != '0) && (len_q == dt_i - 1'b1);
            end
            assign pre_o = pre_q;
        end else begin : g_nopre
            assign pre_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/fwd_pwm.sv
// Module: fwd_pwm (top)
// Switching waveform generator for a forward converter with synchronous
// rectification: fixed period, on-time of at most half the period, cut short
// by a peak-current comparator, with complementary gates and dead-time.
// Assumes: all inputs except cmp_trip are synchronous to clk.
module fwd_pwm
    import fpwm_pkg::*;
#(
    parameter int PERIOD = 480,
    parameter int ON_MAX = 240,
    parameter int DT_W   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic [DT_W-1:0] dead_cfg,
    input  logic            cmp_trip,
    output logic            gate_main,
    output logic            gate_comp,
    output logic            period_tc,
    output logic            sample_stb
);
    localparam int CNT_W = $clog2(PERIOD);
    localparam int N_CH  = 2;

    logic [CNT_W-1:0] cnt;
    logic             win;
    logic             last;
    logic             run;
    logic [DT_W-1:0]  dt_q;
    logic             rise;
    logic             ref_on;
    logic [N_CH-1:0]  src;
    logic [N_CH-1:0]  gate;
    logic [N_CH-1:0]  pre;

    fpwm_timebase #(
        .PERIOD(PERIOD),
        .ON_MAX(ON_MAX),
        .DT_W  (DT_W)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .dead_cfg(dead_cfg),
        .cnt_o   (cnt),
        .win_o   (win),
        .last_o  (last),
        .run_o   (run),
        .dt_o    (dt_q),
        .tc_o    (period_tc)
    );

    fpwm_cmp_edge u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .cmp_in(cmp_trip),
        .rise_o(rise)
    );

    fpwm_onctl u_on (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .win_i (win),
        .last_i(last),
        .rise_i(rise),
        .ref_o (ref_on)
    );

    // Channel sources: the reference, and its complement while running.
    always_comb begin
        src[0] = ref_on;
        src[1] = run && !ref_on;
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_ch
            fpwm_dt_chan #(
                .DT_W(DT_W),
                .KIND((g == 0) ? CH_MAIN : CH_COMP)
            ) u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .src_i (src[g]),
                .dt_i  (dt_q),
                .gate_o(gate[g]),
                .pre_o (pre[g])
            );
        end
    endgenerate

    assign gate_main  = gate[0];
    assign gate_comp  = gate[1];
    assign sample_stb = |pre;
endmodule

// File: rtl/fwd_pwm_chk.sv
// Module: fwd_pwm_chk
// Property checker attached to fwd_pwm by bind; it observes ports and the count.
module fwd_pwm_chk #(
    parameter int PERIOD = 480,
    parameter int ON_MAX = 240,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             gate_main,
    input logic             gate_comp,
    input logic             period_tc,
    input logic             sample_stb,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ON_LIM = CNT_W'(ON_MAX);

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_main && gate_comp));

    p_tc_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        period_tc |=> !period_tc);

    p_stb_in_dead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!gate_main && !gate_comp));

    p_main_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gate_main |-> ($past(cnt) < ON_LIM));

    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable, 2) == 1'b0) |-> (!gate_main && !gate_comp && !sample_stb));
endmodule

bind fwd_pwm fwd_pwm_chk #(
    .PERIOD(PERIOD),
    .ON_MAX(ON_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .gate_main (gate_main),
    .gate_comp (gate_comp),
    .period_tc (period_tc),
    .sample_stb(sample_stb),
    .cnt       (cnt)
);

// File: tb/fwd_pwm_tb_top.sv
module fwd_pwm_tb_top;
    localparam int P  = 480;
    localparam int ON = 240;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] dt = 8'd0;
    logic       cmp = 1'b0;
    logic       g_main, g_comp, tc, stb;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fwd_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .enable(en), .dead_cfg(dt), .cmp_trip(cmp),
        .gate_main(g_main), .gate_comp(g_comp), .period_tc(tc), .sample_stb(stb)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_cnt, m_run, m_dt, m_term, m_hi, m_lo, m_s1, m_s2, m_s3;
    int e_main, e_comp, e_tc, e_stb;
    always @(posedge clk) begin
        int refp, rise;
        if (!rst_n) begin
            m_cnt = 0; m_run = 0; m_dt = 0; m_term = 0; m_hi = 0; m_lo = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            e_main = 0; e_comp = 0; e_tc = 0; e_stb = 0;
        end else begin
            refp   = (m_run != 0 && m_cnt < ON && m_term == 0) ? 1 : 0;
            rise   = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            e_main = (refp == 1 && m_hi >= m_dt) ? 1 : 0;
            e_comp = (m_run == 1 && refp == 0 && m_lo >= m_dt) ? 1 : 0;
            e_stb  = (refp == 1 && m_dt > 0 && m_hi == m_dt - 1) ? 1 : 0;
            e_tc   = (m_cnt == P - 1) ? 1 : 0;
            m_hi   = refp ? ((m_hi < 255) ? m_hi + 1 : 255) : 0;
            m_lo   = (m_run == 1 && refp == 0) ? ((m_lo < 255) ? m_lo + 1 : 255) : 0;
            if (m_cnt == P - 1) m_term = 0; else if (rise) m_term = 1;
            if (m_cnt == P - 1) m_dt = int'(dt);
            if (!en) m_run = 0; else if (m_cnt == P - 1) m_run = 1;
            m_cnt = (m_cnt + 1) % P;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(cmp);
        end
    end

    // Per-clock comparison and per-period measurement windows.
    int acc_main, acc_comp, acc_stb, pos, stb_pos, tcs;
    int last_main, last_comp, last_stb, last_stb_pos, last_gap;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1 period_tc vs model", int'(tc), e_tc);
            chk("R2 gate_main vs model", int'(g_main), e_main);
            chk("R5 gate_comp vs model", int'(g_comp), e_comp);
            chk("R9 sample_stb vs model", int'(stb), e_stb);
            chk("R5 gates overlap", int'(g_main && g_comp), 0);
            if (tc) begin
                last_main = acc_main; last_comp = acc_comp; last_stb = acc_stb;
                last_stb_pos = stb_pos; last_gap = pos + 1; tcs++;
                acc_main = int'(g_main); acc_comp = int'(g_comp); acc_stb = int'(stb);
                pos = 0; stb_pos = stb ? 0 : -1;
            end else begin
                pos++;
                acc_main += int'(g_main); acc_comp += int'(g_comp); acc_stb += int'(stb);
                if (stb) stb_pos = pos;
            end
        end
    end

    task automatic wait_tc();
        do @(negedge clk); while (!tc);
        #1;
    endtask

    // Watchdog: a hung run counts as a failed check.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        acc_main = 0; acc_comp = 0; acc_stb = 0; pos = 0; stb_pos = -1; tcs = 0;
        repeat (5) @(negedge clk);
        chk("R8 reset gates low", int'(g_main || g_comp), 0);
        chk("R8 reset strobe and tc low", int'(stb || tc), 0);
        rst_n = 1'b1;

        repeat (3) wait_tc();
        chk("R10 tc spacing while disabled", last_gap, P);
        chk("R8 idle main", last_main, 0);
        chk("R8 idle comp", last_comp, 0);

        en = 1'b1;
        wait_tc();
        chk("R8 enable waits for boundary", last_main, 0);
        wait_tc();
        chk("R2 full reference width", last_main, ON);
        wait_tc();
        chk("R2 comp width dt0", last_comp, P - ON);
        chk("R1 tc spacing", last_gap, P);
        chk("R9 no strobe at dt0", last_stb, 0);

        dt = 8'd10;
        wait_tc(); wait_tc();
        chk("R5 main width dt10", last_main, ON - 10);
        chk("R5 comp width dt10", last_comp, P - ON - 10);
        chk("R9 one strobe", last_stb, 1);
        chk("R9 strobe offset", last_stb_pos, 10);

        repeat (100) @(negedge clk);
        dt = 8'd40;
        wait_tc();
        chk("R6 mid-period change ignored main", last_main, ON - 10);
        chk("R6 mid-period change ignored comp", last_comp, P - ON - 10);
        wait_tc();
        chk("R6 new dead-time applied", last_main, ON - 40);
        chk("R6 new dead-time comp", last_comp, P - ON - 40);

        dt = 8'd0;
        wait_tc(); wait_tc();
        repeat (50) @(negedge clk);
        cmp = 1'b1;
        repeat (5) @(negedge clk);
        cmp = 1'b0;
        repeat (45) @(negedge clk);
        cmp = 1'b1;
        repeat (5) @(negedge clk);
        cmp = 1'b0;
        wait_tc();
        chk("R4 R3 first edge ends pulse", last_main, 53);
        chk("R3 second edge ignored, comp", last_comp, P - 53);

        repeat (300) @(negedge clk);
        cmp = 1'b1;
        repeat (3) @(negedge clk);
        cmp = 1'b0;
        wait_tc();
        chk("R3 edge outside window", last_main, ON);
        dt = 8'd60;
        wait_tc();
        chk("R3 no carry into next period", last_main, ON);

        repeat (30) @(negedge clk);
        cmp = 1'b1;
        repeat (3) @(negedge clk);
        cmp = 1'b0;
        wait_tc();
        chk("R7 short pulse gives no main", last_main, 0);
        chk("R7 no strobe for short pulse", last_stb, 0);
        chk("R7 comp after long dead-time", last_comp, 387);

        repeat (100) @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 disable forces gates low", int'(g_main || g_comp), 0);
        wait_tc(); wait_tc();
        chk("R8 disabled main", last_main, 0);
        chk("R8 disabled comp", last_comp, 0);
        chk("R10 tc after disable", last_gap, P);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule